// File: doc/BRIEF.md
# Outbound Address Translation Region Table

This block holds a table of outbound translation regions and maps a local address, together with a region number, onto a 64-bit link-side address. Region 0 spans a 32 MiB window; each of the remaining regions spans a 1 MiB slice, and those slices together cover the same 32 MiB. Every region is programmed through a simple write-only register bus and carries four 32-bit words: a low address word, a high address word and two descriptor words.

A lookup is purely combinational over the registered configuration. The low address word holds a pass-through count N and bits 31:8 of the translated base. The input address bits 0 to N are carried through unchanged. The bits above N come from the region base, which is formed from the high word, the low word bits 31:8 and eight zero bits. The result carries the region's transaction type and a valid flag. The valid flag is raised only when the region number exists, the region is enabled and N lies in the range allowed for that region.

Top module: `obt_table`

## Requirements
- R1: After reset every region is disabled: for every index 0 to 63 the lookup gives xlatValid = 0, xlatAddr = 0 and xlatType = 0.
- R2: A write lands in region cfgAddr[10:5] at word cfgAddr[3:2] (0 = address-low, 1 = address-high, 2 = descriptor-0, 3 = descriptor-1). A write is ignored if cfgAddr[4] is 1, if cfgAddr[1:0] is not 0, or if the region number is 33 or above. A write to one region leaves every other region unchanged.
- R3: For a valid lookup, bits 0 to N of xlatAddr equal the zero-extended input address bits. Bits 63 down to N+1 equal the base {address-high, address-low[31:8], 8'h00}.
- R4: N is address-low bits 5:0, and address-low bits 7:6 have no effect. A region whose N is below 7 never gives a valid lookup.
- R5: Region 0 is valid only with N at most 24 (a window of at most 32 MiB).
- R6: Regions 1 to 32 are valid only with N at most 19 (a window of at most 1 MiB).
- R7: Descriptor-0 bit 23 enables the region, and descriptor-0 bits 3:0 appear on xlatType (2 = memory write, 6 = I/O write). When xlatValid is 0, xlatAddr and xlatType are 0.
- R8: A region index of 33 or above gives xlatValid = 0 whatever region 0 holds.
- R9: A write is seen by the lookup from the clock cycle after the write. A lookup in the cycle of the write returns the old contents.
- R10: Writes to descriptor-1 have no effect on any lookup output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 11 | Register byte address |
| cfgWrData | input | 32 | Register write data |
| inRegion | input | 6 | Region number of the lookup |
| inAddr | input | 32 | Local address to translate |
| xlatAddr | output | 64 | Translated address |
| xlatType | output | 4 | Transaction type of the selected region |
| xlatValid | output | 1 | Translation valid |

## Verification
A register write and a lookup of the same region can happen in one cycle. The bench sets up this collision by presenting a lookup on region 3 in the same cycle as a write that disables the region, and then again with a write that re-enables it. It samples the outputs before the clock edge, where the old configuration must still show, and again one cycle later, where the new one must show. Alongside this, N is swept over all 64 values on region 0, on two middle regions and on the last region, and every output is compared with a value the bench computes arithmetically.

// File: rtl/obt_pkg.sv
package obt_pkg;
  // Field layout of the address-low word
  localparam int PASS_W   = 6;
  localparam int BASE_LSB = 8;

  // Write strobes from the decode to the register storage
  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic wrDesc0;
  } obtStrobes_t;
endpackage

// File: rtl/obt_ctrl.sv
module obt_ctrl
  import obt_pkg::*;
#(
  parameter int NUM_REGIONS = 33,
  parameter int IDX_W       = 6,
  parameter int CFG_AW      = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  output obtStrobes_t       strb,
  output logic [IDX_W-1:0]  strbRegion
);
  localparam logic [IDX_W:0] REGION_COUNT = (IDX_W+1)'(NUM_REGIONS);

  logic [IDX_W-1:0] regionField;
  logic [1:0]       wordSel;
  logic             legal;

  assign regionField = cfgAddr[CFG_AW-1:5];
  assign wordSel     = cfgAddr[3:2];
  assign legal       = cfgWrEn && (cfgAddr[1:0] == 2'b00) && !cfgAddr[4]
                       && ({1'b0, regionField} < REGION_COUNT);

  // Word 3 (descriptor-1) is accepted but holds nothing that a lookup uses
  always_comb begin
    strb.wrLow   = legal && (wordSel == 2'd0);
    strb.wrHigh  = legal && (wordSel == 2'd1);
    strb.wrDesc0 = legal && (wordSel == 2'd2);
  end
  assign strbRegion = regionField;

  // R2
  strb_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLow || strb.wrHigh || strb.wrDesc0) |->
      (cfgWrEn && !cfgAddr[4] && ({1'b0, strbRegion} < REGION_COUNT)));
endmodule

// File: rtl/obt_datapath.sv
module obt_datapath
  import obt_pkg::*;
#(
  parameter int NUM_REGIONS  = 33,
  parameter int IDX_W        = 6,
  parameter int IN_AW        = 32,
  parameter int TYPE_W       = 4,
  parameter int ENABLE_BIT   = 23,
  parameter int MIN_PASS     = 8,
  parameter int REGION0_LOG2 = 25,
  parameter int REGIONN_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  obtStrobes_t       strb,
  input  logic [IDX_W-1:0]  strbRegion,
  input  logic [31:0]       wrData,
  input  logic [IDX_W-1:0]  inRegion,
  input  logic [IN_AW-1:0]  inAddr,
  output logic [63:0]       xlatAddr,
  output logic [TYPE_W-1:0] xlatType,
  output logic              xlatValid
);
  localparam logic [IDX_W:0]    REGION_COUNT = (IDX_W+1)'(NUM_REGIONS);
  localparam logic [PASS_W-1:0] MIN_N  = PASS_W'(MIN_PASS - 1);
  localparam logic [PASS_W-1:0] R0_MAXN = PASS_W'(REGION0_LOG2 - 1);
  localparam logic [PASS_W-1:0] RN_MAXN = PASS_W'(REGIONN_LOG2 - 1);
  localparam int BASE_W = 32 - BASE_LSB;

  logic [PASS_W-1:0] passN  [NUM_REGIONS];
  logic [BASE_W-1:0] baseLo [NUM_REGIONS];
  logic [31:0]       baseHi [NUM_REGIONS];
  logic [TYPE_W-1:0] kind   [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] regionOk;

  // Data bits that no stored field takes
  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[BASE_LSB-1:PASS_W], wrData[31:ENABLE_BIT+1],
                          wrData[ENABLE_BIT-1:TYPE_W]};

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    localparam logic [PASS_W-1:0] MAXN = (i == 0) ? R0_MAXN : RN_MAXN;
    logic [PASS_W-1:0] passR;
    logic [BASE_W-1:0] loR;
    logic [31:0]       hiR;
    logic [TYPE_W-1:0] kindR;
    logic              enR;
    logic              hitWr;

    assign hitWr = (strbRegion == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        passR <= '0;
        loR   <= '0;
        hiR   <= '0;
        kindR <= '0;
        enR   <= 1'b0;
      end else if (hitWr) begin
        if (strb.wrLow) begin
          passR <= wrData[PASS_W-1:0];
          loR   <= wrData[31:BASE_LSB];
        end
        if (strb.wrHigh) hiR <= wrData;
        if (strb.wrDesc0) begin
          kindR <= wrData[TYPE_W-1:0];
          enR   <= wrData[ENABLE_BIT];
        end
      end
    end

    assign passN[i]    = passR;
    assign baseLo[i]   = loR;
    assign baseHi[i]   = hiR;
    assign kind[i]     = kindR;
    assign regionOk[i] = enR && (passR >= MIN_N) && (passR <= MAXN);
  end

  logic             inRange;
  logic [IDX_W-1:0] selIdx;
  logic [63:0]      base;
  logic [63:0]      passMask;
  logic             hit;

  always_comb begin
    inRange  = ({1'b0, inRegion} < REGION_COUNT);
    selIdx   = inRange ? inRegion : '0;
    base     = {baseHi[selIdx], baseLo[selIdx], {BASE_LSB{1'b0}}};
    passMask = ~(64'hFFFF_FFFF_FFFF_FFFE << passN[selIdx]);
    hit      = inRange && regionOk[selIdx];
    xlatValid = hit;
    xlatAddr  = hit ? ((base & ~passMask) |
                       ({{(64-IN_AW){1'b0}}, inAddr} & passMask)) : '0;
    xlatType  = hit ? kind[selIdx] : '0;
  end

  // R8
  valid_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlatValid |-> ({1'b0, inRegion} < REGION_COUNT));

  // R3
  low_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlatValid |-> (xlatAddr[MIN_PASS-1:0] == inAddr[MIN_PASS-1:0]));

  // R7
  disable_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDesc0 && !wrData[ENABLE_BIT]) |=>
      ((inRegion != $past(strbRegion)) || !xlatValid));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.wrLow || strb.wrHigh || strb.wrDesc0) &&
     $stable(inRegion) && $stable(inAddr)) |->
      ($stable(xlatAddr) && $stable(xlatValid) && $stable(xlatType)));
endmodule

// File: rtl/obt_table.sv
module obt_table
  import obt_pkg::*;
#(
  parameter int NUM_REGIONS  = 33,
  parameter int IN_AW        = 32,
  parameter int TYPE_W       = 4,
  parameter int ENABLE_BIT   = 23,
  parameter int MIN_PASS     = 8,
  parameter int REGION0_LOG2 = 25,
  parameter int REGIONN_LOG2 = 20,
  localparam int IDX_W       = $clog2(NUM_REGIONS),
  localparam int CFG_AW      = IDX_W + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  logic [IDX_W-1:0]  inRegion,
  input  logic [IN_AW-1:0]  inAddr,
  output logic [63:0]       xlatAddr,
  output logic [TYPE_W-1:0] xlatType,
  output logic              xlatValid
);
  obtStrobes_t      strb;
  logic [IDX_W-1:0] strbRegion;

  obt_ctrl #(
    .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W), .CFG_AW(CFG_AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .strb(strb), .strbRegion(strbRegion)
  );

  obt_datapath #(
    .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W), .IN_AW(IN_AW),
    .TYPE_W(TYPE_W), .ENABLE_BIT(ENABLE_BIT), .MIN_PASS(MIN_PASS),
    .REGION0_LOG2(REGION0_LOG2), .REGIONN_LOG2(REGIONN_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .strbRegion(strbRegion),
    .wrData(cfgWrData), .inRegion(inRegion), .inAddr(inAddr),
    .xlatAddr(xlatAddr), .xlatType(xlatType), .xlatValid(xlatValid)
  );
endmodule

// File: tb/obt_table_tb.sv
`timescale 1ns/1ps
module obt_table_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [10:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [5:0]  inRegion = '0;
  logic [31:0] inAddr = '0;
  logic [63:0] xlatAddr;
  logic [3:0]  xlatType;
  logic        xlatValid;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  obt_table u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .inRegion(inRegion), .inAddr(inAddr),
    .xlatAddr(xlatAddr), .xlatType(xlatType), .xlatValid(xlatValid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 11'(addr); cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic prog(input int r, input int n, input logic [23:0] lb,
                      input logic [31:0] hi, input bit en, input logic [3:0] typ);
    wr(r*32 + 0, {lb, 2'b11, 6'(n)});
    wr(r*32 + 4, hi);
    wr(r*32 + 8, {8'hC3, en, 19'h7FFF0, typ});
  endtask

  function automatic logic [63:0] expAddr(input logic [31:0] hi, input logic [23:0] lb,
                                          input int n, input logic [31:0] a);
    logic [63:0] b, m;
    b = {hi, lb, 8'h00};
    m = (n >= 63) ? '1 : ((64'd1 << (n+1)) - 64'd1);
    return (b & ~m) | ({32'h0, a} & m);
  endfunction

  function automatic bit expValid(input int r, input int n, input bit en);
    return (r < 33) && en && (n >= 7) && (n <= ((r == 0) ? 24 : 19));
  endfunction

  // Present a lookup and compare all three outputs
  task automatic look(input int r, input logic [31:0] a, input bit ev,
                      input logic [63:0] ea, input logic [3:0] et, input string tag);
    inRegion = 6'(r); inAddr = a;
    #1;
    chk(xlatValid == ev, {tag, " valid"}, 64'(xlatValid), 64'(ev));
    chk(xlatAddr == (ev ? ea : 64'h0), {tag, " addr"}, xlatAddr, ev ? ea : 64'h0);
    chk(xlatType == (ev ? et : 4'h0), {tag, " type"}, 64'(xlatType), 64'(ev ? et : 4'h0));
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int sweepRegions[4] = '{0, 1, 16, 32};
    logic [31:0] addrs[2] = '{32'hFFFF_FFFF, 32'h1234_5678};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state over every index
    for (int r = 0; r < 64; r++) look(r, 32'hDEAD_BEEF, 1'b0, 64'h0, 4'h0, "R1");

    // R3 R4 R5 R6 R7: exhaustive N sweep on boundary regions
    foreach (sweepRegions[k]) begin
      for (int n = 0; n < 64; n++) begin
        int r = sweepRegions[k];
        logic [31:0] hi = 32'hA000_0000 + 32'(r*256 + n);
        logic [23:0] lb = 24'h5A5A00 ^ 24'(n*4099);
        logic [3:0]  typ = n[0] ? 4'h6 : 4'h2;
        string tag = (n < 7) ? "R4" : ((r == 0) ? "R5" : ((n > 19) ? "R6" : "R3"));
        prog(r, n, lb, hi, 1'b1, typ);
        foreach (addrs[j])
          look(r, addrs[j], expValid(r, n, 1'b1), expAddr(hi, lb, n, addrs[j]), typ, tag);
      end
    end

    // R8: region 0 valid, indices past the table stay invalid
    prog(0, 12, 24'h112233, 32'h4455_6677, 1'b1, 4'h2);
    look(0, 32'h0000_0ABC, 1'b1, expAddr(32'h4455_6677, 24'h112233, 12, 32'h0000_0ABC), 4'h2, "R8 ref");
    look(33, 32'h0000_0ABC, 1'b0, 64'h0, 4'h0, "R8 idx33");
    look(63, 32'h0000_0ABC, 1'b0, 64'h0, 4'h0, "R8 idx63");

    // R7: enable bit cleared disables region
    prog(7, 10, 24'hABCDEF, 32'h0000_0001, 1'b0, 4'h6);
    look(7, 32'h0000_0123, 1'b0, 64'h0, 4'h0, "R7 disabled");
    wr(7*32 + 8, 32'h0080_0006);
    look(7, 32'h0000_0123, 1'b1, expAddr(32'h1, 24'hABCDEF, 10, 32'h123), 4'h6, "R7 enabled");

    // R2: neighbours untouched, bit4 and misaligned writes ignored
    prog(5, 15, 24'h00F00F, 32'h8765_4321, 1'b1, 4'h2);
    look(4, 32'h5555, 1'b0, 64'h0, 4'h0, "R2 nbr4");
    look(6, 32'h5555, 1'b0, 64'h0, 4'h0, "R2 nbr6");
    prog(6, 9, 24'h777777, 32'h1, 1'b1, 4'h6);
    look(5, 32'h5555, 1'b1, expAddr(32'h8765_4321, 24'h00F00F, 15, 32'h5555), 4'h2, "R2 keep5");
    wr(5*32 + 16, 32'h0);
    wr(5*32 + 24, 32'h0);
    wr(5*32 + 9, 32'h0);
    wr(5*32 + 1, 32'h0000_0001);
    wr(33*32 + 8, 32'h0080_0006);
    look(5, 32'h5555, 1'b1, expAddr(32'h8765_4321, 24'h00F00F, 15, 32'h5555), 4'h2, "R2 ignored");

    // R10: descriptor-1 writes change nothing
    wr(5*32 + 12, 32'hFFFF_FFFF);
    wr(5*32 + 12, 32'h0);
    look(5, 32'h5555, 1'b1, expAddr(32'h8765_4321, 24'h00F00F, 15, 32'h5555), 4'h2, "R10");

    // R9: write and lookup of the same region in one cycle
    prog(3, 7, 24'h010203, 32'hCAFE_0000, 1'b1, 4'h2);
    @(negedge clk);
    inRegion = 6'd3; inAddr = 32'h0000_00FF;
    cfgWrEn = 1'b1; cfgAddr = 11'(3*32 + 8); cfgWrData = 32'h0000_0002;
    #1;
    chk(xlatValid == 1'b1, "R9 old-before-edge", 64'(xlatValid), 64'd1);
    @(negedge clk);
    cfgWrEn = 1'b0;
    #1;
    chk(xlatValid == 1'b0, "R9 new-after-edge", 64'(xlatValid), 64'd0);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 11'(3*32 + 8); cfgWrData = 32'h0080_0006;
    #1;
    chk(xlatValid == 1'b0, "R9 old-disabled", 64'(xlatValid), 64'd0);
    @(negedge clk);
    cfgWrEn = 1'b0;
    #1;
    chk(xlatValid == 1'b1, "R9 re-enabled", 64'(xlatValid), 64'd1);
    chk(xlatType == 4'h6, "R9 type", 64'(xlatType), 64'd6);
    chk(xlatAddr == expAddr(32'hCAFE_0000, 24'h010203, 7, 32'hFF), "R9 addr",
        xlatAddr, expAddr(32'hCAFE_0000, 24'h010203, 7, 32'hFF));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule